// File: doc/BRIEF.md
# Edge-Interrupt General-Purpose Port

An 8-bit general-purpose I/O port with a byte-wide register interface. Each bit is an input or an output, set by a direction register. An output latch drives the pins that are outputs. A data read returns a mix: the sampled pin level for input bits and the latch value for output bits.

Every bit also has a polarity bit that chooses which pin transition counts as an event. The port samples its pins once per clock. It compares each sampled level against that bit's polarity and raises a one-cycle strobe when the comparison turns true. The comparison is evaluated again every cycle, so rewriting the polarity register is treated the same way as a pin change. The eight strobes leave the block two ways: as a plain vector, and spread over a 16-bit interrupt-source vector for a separate interrupt controller.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the output latch, direction and polarity registers are all zero, rdata_o is 0, and no strobe is active.
- R2: A write to address 0 loads the output latch, and a write to address 2 loads the direction register (1 = output). pin_o always shows the latch and pin_oe_o always shows the direction register, one cycle after the write.
- R3: A read with rd_i high loads rdata_o at the next clock, and rdata_o holds that value until the next read. At address 0 the read returns, bit by bit, the sampled pin for input bits and the output latch for output bits.
- R4: With polarity bit 1 on an input bit, a 0-to-1 change of that pin gives exactly one strobe. The strobe is high for a single cycle, in the second clock cycle after the pin changes. A 1-to-0 change gives no strobe.
- R5: With polarity bit 0 on an input bit, a 1-to-0 pin change gives exactly one single-cycle strobe and a 0-to-1 change gives none.
- R6: A strobe fires whenever (sampled pin XNOR polarity bit) goes from 0 to 1, including when it is caused by a write to the polarity register (address 1) while the pin is steady. For example, a pin held at 0 with its polarity changed from 1 to 0 gives a strobe.
- R7: A bit whose direction is output never strobes. Changing a bit from output to input with its pin steady produces no strobe.
- R8: Strobe bits 0..7 appear on src_o bits 0, 1, 2, 3, 6, 7, 14 and 15, in that order. src_o bits 4, 5 and 8..13 are always 0.
- R9: Address 3 is reserved. A write there changes no register, and a read there returns 0.
- R10: Reads at addresses 1 and 2 return the polarity and direction registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register select: 0 data, 1 polarity, 2 direction, 3 reserved |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, registered |
| pin_i | input | 8 | Pin levels from the pads |
| pin_o | output | 8 | Output latch to the pads |
| pin_oe_o | output | 8 | Per-bit output enable (direction register) |
| evt_o | output | 8 | Per-bit single-cycle event strobes |
| src_o | output | 16 | Strobes placed on interrupt-source positions |

## Verification
The bench targets strobes that come from a polarity rewrite while the pins are steady. A design that watched only pin changes would miss these, and a design that treated any level change as an event would double them. It also toggles pins on bits set as outputs and then turns those bits back into inputs. A design that masked only the comparison, rather than the strobe, would then fire a false event. A single event on port bit 6 must land at source bit 14, which catches a straight bit-for-bit copy. Mixed readback with half the bits as outputs checks the per-bit selection, and writes to the reserved address check that no register changes.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int PORT_W = 8;
  localparam int SRC_W  = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_POL  = 2'd1,
    REG_DIR  = 2'd2,
    REG_RSVD = 2'd3
  } reg_sel_e;

  // port bit -> interrupt source position
  function automatic int src_pos(int i);
    if (i < 4)      return i;
    else if (i < 6) return i + 2;
    else            return i + 8;
  endfunction
endpackage

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
  import gpio_edge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [PORT_W-1:0] in_i,
  output logic [PORT_W-1:0] out_o,
  output logic [PORT_W-1:0] dir_o,
  output logic [PORT_W-1:0] pol_o,
  output logic [PORT_W-1:0] rdata_o
);
  logic [PORT_W-1:0] out_q, dir_q, pol_q, rdata_q, rd_mux;
  reg_sel_e sel;

  assign sel = reg_sel_e'(addr_i);

  always_comb begin
    unique case (sel)
      REG_DATA: rd_mux = (in_i & ~dir_q) | (out_q & dir_q);
      REG_POL:  rd_mux = pol_q;
      REG_DIR:  rd_mux = dir_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= '0;
      pol_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (rd_i) rdata_q <= rd_mux;
      if (wr_i) begin
        unique case (sel)
          REG_DATA: out_q <= wdata_i;
          REG_POL:  pol_q <= wdata_i;
          REG_DIR:  dir_q <= wdata_i;
          default:  ;
        endcase
      end
    end
  end

  assign out_o   = out_q;
  assign dir_o   = dir_q;
  assign pol_o   = pol_q;
  assign rdata_o = rdata_q;

  a_r2_dir_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel == REG_DIR) |=> (dir_q == $past(wdata_i)));
  a_r2_out_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel == REG_DATA) |=> (out_q == $past(wdata_i)));
  a_r9_rsvd_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel == REG_RSVD) |=> ($stable(out_q) && $stable(dir_q) && $stable(pol_q)));
  a_r3_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_q));
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
  import gpio_edge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] pin_i,
  input  logic [PORT_W-1:0] dir_i,
  input  logic [PORT_W-1:0] pol_i,
  output logic [PORT_W-1:0] in_o,
  output logic [PORT_W-1:0] evt_o
);
  logic [PORT_W-1:0] in_q, lvl_q, evt_q, lvl;

  // active level: pin agrees with polarity
  assign lvl = ~(in_q ^ pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      lvl_q <= '1;
      evt_q <= '0;
    end else begin
      in_q  <= pin_i;
      lvl_q <= lvl;
      evt_q <= lvl & ~lvl_q & ~dir_i;
    end
  end

  assign in_o  = in_q;
  assign evt_o = evt_q;

  a_r7_no_output_evt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q & $past(dir_i)) == '0);
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q & $past(evt_q)) == '0);
endmodule

// File: rtl/gpio_edge_srcmap.sv
module gpio_edge_srcmap
  import gpio_edge_pkg::*;
(
  input  logic [PORT_W-1:0] evt_i,
  output logic [SRC_W-1:0]  src_o
);
  always_comb begin
    src_o = '0;
    for (int i = 0; i < PORT_W; i++) src_o[src_pos(i)] = evt_i[i];
  end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [PORT_W-1:0] rdata_o,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] pin_o,
  output logic [PORT_W-1:0] pin_oe_o,
  output logic [PORT_W-1:0] evt_o,
  output logic [SRC_W-1:0]  src_o
);
  logic [PORT_W-1:0] in_s, dir_s, pol_s, out_s, evt_s;

  gpio_edge_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .in_i    (in_s),
    .out_o   (out_s),
    .dir_o   (dir_s),
    .pol_o   (pol_s),
    .rdata_o (rdata_o)
  );

  gpio_edge_detect u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .dir_i  (dir_s),
    .pol_i  (pol_s),
    .in_o   (in_s),
    .evt_o  (evt_s)
  );

  gpio_edge_srcmap u_map (
    .evt_i (evt_s),
    .src_o (src_o)
  );

  assign pin_o    = out_s;
  assign pin_oe_o = dir_s;
  assign evt_o    = evt_s;

  a_r8_src_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(src_o) == $countones(evt_o));
  a_r8_src_unused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_o & 16'h3F30) == '0);
endmodule

// File: tb/gpio_edge_port_test.sv
module gpio_edge_port_test;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [1:0]  addr_i = 0;
  logic [7:0]  wdata_i = 0;
  logic        wr_i = 0;
  logic        rd_i = 0;
  logic [7:0]  pin_i = 0;
  logic [7:0]  rdata_o, pin_o, pin_oe_o, evt_o;
  logic [15:0] src_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  gpio_edge_port uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .evt_o(evt_o), .src_o(src_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit [7:0] m_in, m_out, m_dir, m_pol, m_prev, m_evt, m_rdata;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_in = 0; m_out = 0; m_dir = 0; m_pol = 0; m_prev = 8'hFF; m_evt = 0; m_rdata = 0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        bit cur;
        cur = (m_in[i] == m_pol[i]);
        m_evt[i] = cur && !m_prev[i] && !m_dir[i];
        m_prev[i] = cur;
      end
      if (rd_i) begin
        case (addr_i)
          2'd0: for (int i = 0; i < 8; i++) m_rdata[i] = m_dir[i] ? m_out[i] : m_in[i];
          2'd1: m_rdata = m_pol;
          2'd2: m_rdata = m_dir;
          default: m_rdata = 0;
        endcase
      end
      if (wr_i) begin
        case (addr_i)
          2'd0: m_out = wdata_i;
          2'd1: m_pol = wdata_i;
          2'd2: m_dir = wdata_i;
          default: ;
        endcase
      end
      m_in = pin_i;
    end
  end

  // compare every cycle
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit [15:0] exp_src;
      exp_src = 0;
      for (int i = 0; i < 8; i++) begin
        int p;
        p = (i < 4) ? i : (i < 6) ? i + 2 : i + 8;
        exp_src[p] = m_evt[i];
      end
      check("R3 rdata", rdata_o, m_rdata);
      check("R2 pin_o", pin_o, m_out);
      check("R2 pin_oe_o", pin_oe_o, m_dir);
      check("R4/R5/R6/R7 evt", evt_o, m_evt);
      check("R8 src", src_o, exp_src);
    end
  end

  int pulses;
  bit [7:0]  seen;
  bit [15:0] src_cap;

  task automatic tick(int n = 1);
    repeat (n) begin
      @(negedge clk_i);
      for (int i = 0; i < 8; i++) if (evt_o[i]) pulses++;
      seen |= evt_o;
      if (evt_o != 0) src_cap |= src_o;
    end
  endtask

  task automatic clr();
    pulses = 0; seen = 0; src_cap = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1;
    tick();
    wr_i = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr_i = a; rd_i = 1;
    tick();
    rd_i = 0;
    d = rdata_o;
  endtask

  logic [7:0] v;

  initial begin
    clr();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    tick();
    // R1
    check("R1 rdata", rdata_o, 0);
    check("R1 pin_o", pin_o, 0);
    check("R1 pin_oe", pin_oe_o, 0);
    check("R1 evt", evt_o, 0);
    rd(2'd0, v); check("R1 data read", v, 0);
    // R2 / R10
    wr(2'd0, 8'hA5); wr(2'd2, 8'h0F); wr(2'd1, 8'h3C);
    tick();
    check("R2 latch on pins", pin_o, 8'hA5);
    check("R2 oe", pin_oe_o, 8'h0F);
    rd(2'd2, v); check("R10 dir read", v, 8'h0F);
    rd(2'd1, v); check("R10 pol read", v, 8'h3C);
    // R3 mixed readback
    pin_i = 8'h5A; tick(2);
    rd(2'd0, v); check("R3 mixed read", v, 8'h55);
    tick(2); check("R3 rdata held", rdata_o, 8'h55);
    // R4 rising
    wr(2'd2, 8'h00); pin_i = 8'h00; tick(4);
    wr(2'd1, 8'hFF); tick(4);
    clr();
    pin_i = 8'hFF; tick(4);
    check("R4 rise pulses", pulses, 8);
    check("R4 rise bits", seen, 8'hFF);
    pin_i = 8'h00; tick(4);
    check("R4 no event on fall", pulses, 8);
    // R6 polarity rewrite with steady pins at 0
    clr();
    wr(2'd1, 8'h00); tick(4);
    check("R6 rewrite pulses", pulses, 8);
    // R5 falling
    clr();
    pin_i = 8'hFF; tick(4);
    check("R5 no event on rise", pulses, 0);
    pin_i = 8'h00; tick(4);
    check("R5 fall pulses", pulses, 8);
    // R7 outputs silent
    wr(2'd2, 8'hF0); tick(2);
    clr();
    pin_i = 8'hFF; tick(4); pin_i = 8'h00; tick(4);
    check("R7 only input bits", seen, 8'h0F);
    check("R7 pulse count", pulses, 4);
    clr();
    wr(2'd2, 8'hF0); pin_i = 8'hF0; tick(4);
    wr(2'd2, 8'h00); tick(4);
    check("R7 no event on dir change", pulses, 0);
    pin_i = 8'h00; tick(4);
    // R8 bit 6 -> source 14
    clr();
    pin_i = 8'h40; tick(4); pin_i = 8'h00; tick(4);
    check("R8 bit6 map", src_cap, 16'h4000);
    check("R8 bit6 count", pulses, 1);
    // R9 reserved address
    wr(2'd2, 8'hFF); wr(2'd3, 8'h00); tick();
    rd(2'd2, v); check("R9 dir unchanged", v, 8'hFF);
    rd(2'd0, v); check("R9 latch unchanged", v, 8'hA5);
    rd(2'd3, v); check("R9 reserved read", v, 0);
    // random traffic, checked by the model every cycle
    for (int k = 0; k < 600; k++) begin
      addr_i = 2'($urandom); wdata_i = 8'($urandom);
      wr_i = ($urandom % 4) == 0; rd_i = ($urandom % 3) == 0;
      if (($urandom % 3) == 0) pin_i = 8'($urandom);
      tick();
    end
    wr_i = 0; rd_i = 0;
    tick(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule